// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Flags

This block is a purely combinational integer arithmetic-logic unit whose datapath is a parameterised chain of identical one-bit slices. Each slice holds a full adder, a conditional inverter on its second operand and a small result selector. The carry of each slice feeds the next, so an add ripples from bit 0 up to the most significant bit.

A 3-bit operation code picks bitwise AND, bitwise OR, addition or subtraction. Subtraction does not use a separate subtractor. The second operand is inverted in every slice and the carry into slice 0 is forced high, so the adder forms a plus the two's-complement negation of b. Alongside the result the block reports whether the result is all zeros, the carry out of the top slice, and signed overflow. Overflow is derived from the sign bits of the operands (b taken after any inversion) and of the result. A subtract followed by a look at the zero flag serves as an equality compare.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 3'b000 gives result = a AND b, bit by bit.
- R2: Operation code 3'b001 gives result = a OR b, bit by bit.
- R3: Operation code 3'b010 gives result = low WIDTH bits of a + b, with carry_out equal to bit WIDTH of the unsigned sum.
- R4: Operation code 3'b110 gives result = low WIDTH bits of a - b, formed as a + NOT b + 1.
- R5: For operation code 3'b110, carry_out equals bit WIDTH of the unsigned sum a + NOT b + 1, which is 1 exactly when a >= b taken as unsigned numbers.
- R6: zero is 1 exactly when every result bit is 0, for every operation code; subtracting equal operands therefore sets zero.
- R7: For add and subtract, overflow is 1 exactly when the sign bit of a equals the sign bit of the effective second operand (b for add, NOT b for subtract) and the result sign bit differs from them.
- R8: For AND and OR, carry_out and overflow are both 0.
- R9: The unused operation codes 3'b011, 3'b100, 3'b101 and 3'b111 give result 0, zero 1, carry_out 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| ctrl | input | 3 | Operation code |
| result | output | 32 | Selected result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed two's-complement overflow on add or subtract |
| carry_out | output | 1 | Carry out of the top slice on add or subtract |

## Verification
The embedded checks compare the rippled slice chain against native arithmetic whenever an add or subtract is selected. They also hold the flags at 0 for the logic operations and the unused codes, and require zero for a subtract of equal operands. The exact overflow rule, including the edges of the signed range, is shown only by the bench scenarios. The same holds for the carry and borrow behaviour of subtract and for the operand patterns chosen to exercise the full carry chain. There the bench computes each output independently from the requirements.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_NONE = 2'd3
  } slice_sel_e;

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu_pkg::*;
(
  input  logic [2:0]  op_i,
  output slice_sel_e  sel_o,
  output logic        binv_o,
  output logic        cin0_o,
  output logic        arith_o
);

  always_comb begin
    sel_o   = SEL_NONE;
    binv_o  = 1'b0;
    cin0_o  = 1'b0;
    arith_o = 1'b0;
    case (op_i)
      OP_AND: sel_o = SEL_AND;
      OP_OR:  sel_o = SEL_OR;
      OP_ADD: begin
        sel_o   = SEL_SUM;
        arith_o = 1'b1;
      end
      OP_SUB: begin
        sel_o   = SEL_SUM;
        binv_o  = 1'b1;
        cin0_o  = 1'b1;
        arith_o = 1'b1;
      end
      default: sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       binv_i,
  input  logic       cin_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       beff_o
);

  logic prop;
  logic sum;

  assign beff_o = b_i ^ binv_i;
  assign prop   = a_i ^ beff_o;
  assign sum    = prop ^ cin_i;
  assign cout_o = (prop & cin_i) | (a_i & beff_o);

  always_comb begin
    case (sel_i)
      SEL_AND: res_o = a_i & beff_o;
      SEL_OR:  res_o = a_i | beff_o;
      SEL_SUM: res_o = sum;
      default: res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             a_msb_i,
  input  logic             beff_msb_i,
  input  logic             cout_i,
  input  logic             arith_i,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             carry_o
);

  logic sign_res;
  assign sign_res = res_i[WIDTH-1];

  assign zero_o  = ~|res_i;
  assign ovf_o   = arith_i & ((a_msb_i & beff_msb_i & ~sign_res) |
                              (~a_msb_i & ~beff_msb_i & sign_res));
  assign carry_o = arith_i & cout_i;

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carry_out
);

  localparam int MSB = WIDTH - 1;

  slice_sel_e       sel;
  logic             binv;
  logic             cin0;
  logic             arith;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] beff;

  alu_ctrl_decode u_dec (
    .op_i    (ctrl),
    .sel_o   (sel),
    .binv_o  (binv),
    .cin0_o  (cin0),
    .arith_o (arith)
  );

  assign carry[0] = cin0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_i    (a[i]),
      .b_i    (b[i]),
      .binv_i (binv),
      .cin_i  (carry[i]),
      .sel_i  (sel),
      .res_o  (result[i]),
      .cout_o (carry[i+1]),
      .beff_o (beff[i])
    );
  end

  alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .res_i      (result),
    .a_msb_i    (a[MSB]),
    .beff_msb_i (beff[MSB]),
    .cout_i     (carry[WIDTH]),
    .arith_i    (arith),
    .zero_o     (zero),
    .ovf_o      (overflow),
    .carry_o    (carry_out)
  );

  logic [WIDTH:0] ref_add;
  logic [WIDTH-1:0] ref_sub;
  assign ref_add = {1'b0, a} + {1'b0, b};
  assign ref_sub = a - b;

  always_comb begin
    if (ctrl == 3'b010) begin
      // R3
      add_sum_chk: assert ({carry_out, result} == ref_add);
    end
    if (ctrl == 3'b110) begin
      // R4
      sub_diff_chk: assert (result == ref_sub);
    end
    if (ctrl == 3'b110 && a == b) begin
      // R6
      eq_zero_chk: assert (zero);
    end
    if (ctrl == 3'b000 || ctrl == 3'b001) begin
      // R8
      logic_flags_chk: assert (!carry_out && !overflow);
    end
    if (ctrl == 3'b011 || ctrl == 3'b100 || ctrl == 3'b101 || ctrl == 3'b111) begin
      // R9
      unused_code_chk: assert (result == '0 && zero && !carry_out && !overflow);
    end
  end

endmodule

// File: tb/sim_bitslice_alu.sv
module sim_bitslice_alu;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   ctrl = 3'b000;
  logic [W-1:0] result;
  logic         zero;
  logic         overflow;
  logic         carry_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  bitslice_alu #(.WIDTH(W)) u0 (
    .a         (a),
    .b         (b),
    .ctrl      (ctrl),
    .result    (result),
    .zero      (zero),
    .overflow  (overflow),
    .carry_out (carry_out)
  );

  function automatic logic [W+2:0] model(input logic [W-1:0] x,
                                         input logic [W-1:0] y,
                                         input logic [2:0] op);
    logic [W:0]   s;
    logic [W-1:0] r;
    logic         c, v;
    r = '0; c = 1'b0; v = 1'b0;
    case (op)
      3'b000: r = x & y;                       // R1
      3'b001: r = x | y;                       // R2
      3'b010: begin                            // R3, R7
        s = {1'b0, x} + {1'b0, y};
        r = s[W-1:0]; c = s[W];
        v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
      end
      3'b110: begin                            // R4, R5, R7
        s = {1'b0, x} + {1'b0, ~y} + 1;
        r = s[W-1:0]; c = s[W];
        v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
      end
      default: ;                               // R9
    endcase
    return {r, (r == '0), v, c};               // R6
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] op);
    logic [W+2:0] exp;
    bit bad;
    @(posedge clk);
    a = x; b = y; ctrl = op;
    @(negedge clk);
    exp = model(x, y, op);
    vectors++;
    bad = 1'b0;
    if (result !== exp[W+2:3]) begin
      $display("FAIL %s result op=%b a=%h b=%h act=%h exp=%h", tag_of(op), op, x, y, result, exp[W+2:3]);
      bad = 1'b1;
    end
    if (zero !== exp[2]) begin
      $display("FAIL R6 zero op=%b a=%h b=%h act=%b exp=%b", op, x, y, zero, exp[2]);
      bad = 1'b1;
    end
    if (overflow !== exp[1]) begin
      $display("FAIL %s overflow op=%b a=%h b=%h act=%b exp=%b",
               (op == 3'b010 || op == 3'b110) ? "R7" : (op[1:0] == 2'b00 || op == 3'b001) ? "R8" : "R9",
               op, x, y, overflow, exp[1]);
      bad = 1'b1;
    end
    if (carry_out !== exp[0]) begin
      $display("FAIL %s carry_out op=%b a=%h b=%h act=%b exp=%b",
               (op == 3'b110) ? "R5" : (op == 3'b010) ? "R3" : (op == 3'b000 || op == 3'b001) ? "R8" : "R9",
               op, x, y, carry_out, exp[0]);
      bad = 1'b1;
    end
    if (bad) fails++;
  endtask

  initial begin
    logic [2:0] codes [8];
    void'($urandom(32'd20240611));
    codes = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b011, 3'b100, 3'b101, 3'b111};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs with AND give zero result and zero flag (R1, R6)
    apply('0, '0, 3'b000);
    // R1 / R2 directed
    apply(32'hF0F0_A5A5, 32'h0FF0_FFFF, 3'b000);
    apply(32'hF0F0_0000, 32'h0000_0F0F, 3'b001);
    // R3 full-chain carry and carry out
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);   // R7 positive overflow
    apply(32'h8000_0000, 32'h8000_0000, 3'b010);   // R7 negative overflow, carry
    apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b010);   // mixed signs, no overflow
    // R4 / R5 subtract
    apply(32'd12, 32'd7, 3'b110);
    apply(32'd12, 32'd13, 3'b110);                 // borrow: carry 0
    apply(32'h1234_5678, 32'h1234_5678, 3'b110);   // R6 equality
    apply(32'h8000_0000, 32'h0000_0001, 3'b110);   // R7 overflow on subtract
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);   // R7 overflow on subtract
    apply(32'h0000_0000, 32'h8000_0000, 3'b110);   // R7 zero minus min
    apply(32'h0000_0000, 32'h0000_0000, 3'b110);   // R5 carry 1 when a>=b
    // R8 logic ops with operands that would carry
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000);
    apply(32'h8000_0000, 32'h8000_0000, 3'b001);
    // R9 unused codes with operands that would otherwise produce flags
    for (int k = 4; k < 8; k++) apply(32'hFFFF_FFFF, 32'h8000_0001, codes[k]);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] x, y;
      x = $urandom(); y = $urandom();
      case ($urandom_range(0, 7))
        0: y = x;
        1: x = {1'b0, x[W-2:0]} | 32'h7FFF_0000;
        2: y = ~x;
        default: ;
      endcase
      apply(x, y, codes[$urandom_range(0, 7)]);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule